// File: doc/BRIEF.md
# Cascade Bus-Master Handover Sequencer

This block lets an add-in card take over the shared system bus through a DMA channel that has been set up for cascade operation. When local logic asks for the bus, the block raises its DMA request and waits for the acknowledge. The acknowledge arrives asynchronously, so the block synchronizes it before using it. Once the acknowledge is seen, the block pulls the open-collector master line low. It then gives permission in two steps, each one clock apart. First the card may drive the address and data lines. After one more clock it may issue read and write strobes.

A hold timer starts as soon as the master line is pulled. Refresh of system memory cannot run while the card owns the bus. For that reason the timer forces a release after a configurable number of bus clocks, chosen to stay below the refresh interval. The default is 112 clocks, which is 14 µs at 8 MHz. Whether the card finishes normally or is cut off by the timer, the block gives the bus back in the same order. The command enable is withdrawn first. The drive enable follows one clock later. The master line and the DMA request are freed on the clock after that.

Top module: `casc_master_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, drq_o, master_pull_o, drive_en_o, cmd_en_o and timeout_o are all 0.
- R2: In idle, with req_i high and the synchronized acknowledge low, drq_o rises on the next clock. While req_i is low, dack_i has no effect on drq_o or master_pull_o.
- R3: dack_i passes through a two-stage synchronizer. master_pull_o (1 means the bus line is pulled low) rises on the third rising clock edge after dack_i goes high while drq_o is high.
- R4: drive_en_o rises exactly one clock after master_pull_o rises. cmd_en_o is still 0 in that cycle.
- R5: cmd_en_o rises exactly two clocks after master_pull_o rises.
- R6: done_i sampled high while cmd_en_o is 1 starts the release. cmd_en_o falls on the next clock, drive_en_o falls one clock later, and master_pull_o and drq_o fall together one clock after that.
- R7: master_pull_o never stays high for more than HOLD_LIMIT consecutive clocks. If done_i has not arrived, the release of R6 is forced so that the line is held for exactly HOLD_LIMIT clocks. The forced release starts even when done_i arrives on that same cycle.
- R8: timeout_o goes to 1 on the clock where a forced release starts. It stays at 1 through idle and clears on the clock where drq_o rises for the next request.
- R9: req_i is ignored once the request has been raised. After a release the block stays idle, with drq_o at 0, unless req_i is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Local request for bus ownership |
| dack_i | input | 1 | DMA acknowledge for the cascade channel, asynchronous, 1 = granted |
| done_i | input | 1 | Local transfer finished |
| drq_o | output | 1 | DMA request to the cascade channel |
| master_pull_o | output | 1 | 1 = pull the open-collector master line low, 0 = release it |
| drive_en_o | output | 1 | Address/data lines may be driven |
| cmd_en_o | output | 1 | Read/write strobes may be issued |
| timeout_o | output | 1 | Last ownership was cut off by the hold limit |

## Verification
The assertions rely on a few assumptions about how the inputs behave. The acknowledge is assumed to rise only while the request is raised. It is also assumed to drop once the master line has been released, and to be low again before the next request. HOLD_LIMIT is assumed to be at least 6, so that a command phase exists before the forced release. The random stimulus stays inside these rules. It raises dack_i only after drq_o is observed high, and clears it as soon as master_pull_o falls. It leaves four idle cycles before each new request, which lets the synchronizer settle. done_i is pulsed only while the command phase is observed. The random done delays cover both sides of the forced-release point, and directed cases sit exactly on that point and on either side of it.

// File: rtl/casc_master_pkg.sv
package casc_master_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ASK      = 3'd1,
        ST_GRANT    = 3'd2,
        ST_DRIVE    = 3'd3,
        ST_CMD      = 3'd4,
        ST_DROP_CMD = 3'd5,
        ST_DROP_DRV = 3'd6
    } own_state_e;

    localparam int unsigned DEF_HOLD_LIMIT  = 112;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef struct packed {
        logic drq;
        logic master;
        logic drive;
        logic cmd;
    } bus_ctl_t;

    function automatic bus_ctl_t decode_ctl(own_state_e s);
        bus_ctl_t c;
        c.drq    = (s != ST_IDLE);
        c.master = (s != ST_IDLE) && (s != ST_ASK);
        c.drive  = (s == ST_DRIVE) || (s == ST_CMD) || (s == ST_DROP_CMD);
        c.cmd    = (s == ST_CMD);
        return c;
    endfunction

endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cm_hold_timer.sv
module cm_hold_timer #(
    parameter int unsigned HOLD_LIMIT = 112
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expire_o
);
    localparam int unsigned CW = $clog2(HOLD_LIMIT + 1);
    localparam logic [CW-1:0] CUT_AT = CW'(HOLD_LIMIT - 3);
    localparam logic [CW-1:0] CAP    = CW'(HOLD_LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_i)  cnt <= '0;
        else if (cnt != CAP) cnt <= cnt + 1'b1;
    end

    // cnt counts cycles since the master line was pulled (0 in first cycle);
    // release takes 3 more cycles, so cutting here holds exactly HOLD_LIMIT.
    assign expire_o = run_i && (cnt == CUT_AT);

    a_r7_hold_bound: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt < CAP));
endmodule

// File: rtl/cm_own_fsm.sv
module cm_own_fsm
    import casc_master_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_i,
    input  logic     ack_s_i,
    input  logic     done_i,
    input  logic     expire_i,
    output bus_ctl_t ctl_o,
    output logic     timeout_o
);
    own_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (req_i && !ack_s_i) st_nx = ST_ASK;
            ST_ASK:      if (ack_s_i)           st_nx = ST_GRANT;
            ST_GRANT:                           st_nx = ST_DRIVE;
            ST_DRIVE:                           st_nx = ST_CMD;
            ST_CMD:      if (done_i || expire_i) st_nx = ST_DROP_CMD;
            ST_DROP_CMD:                        st_nx = ST_DROP_DRV;
            ST_DROP_DRV:                        st_nx = ST_IDLE;
            default:                            st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            timeout_o <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_CMD && expire_i)
                timeout_o <= 1'b1;
            else if (st == ST_IDLE && st_nx == ST_ASK)
                timeout_o <= 1'b0;
        end
    end

    assign ctl_o = decode_ctl(st);

    a_r3_grant_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_o.master) |-> $past(ack_s_i));
    a_r4_drive_after_master: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_o.drive) |-> $past(ctl_o.master) && !ctl_o.cmd);
    a_r5_cmd_after_drive: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_o.cmd) |-> $past(ctl_o.drive));
    a_r6_cmd_then_drive: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_o.cmd) |=> $fell(ctl_o.drive));
    a_r6_drive_then_master: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_o.drive) |=> $fell(ctl_o.master) && !ctl_o.drq);
    a_r6_master_needs_drq: assert property (@(posedge clk) disable iff (rst)
        ctl_o.master |-> ctl_o.drq);
    a_r8_timeout_on_cut: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> $fell(ctl_o.cmd));
endmodule

// File: rtl/casc_master_seq.sv
module casc_master_seq
    import casc_master_pkg::*;
#(
    parameter int unsigned HOLD_LIMIT  = DEF_HOLD_LIMIT,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic dack_i,
    input  logic done_i,
    output logic drq_o,
    output logic master_pull_o,
    output logic drive_en_o,
    output logic cmd_en_o,
    output logic timeout_o
);
    logic     ack_s;
    logic     expire;
    bus_ctl_t ctl;

    cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d_i (dack_i), .q_o (ack_s)
    );

    cm_hold_timer #(.HOLD_LIMIT(HOLD_LIMIT)) u_timer (
        .clk (clk), .rst (rst), .run_i (ctl.master), .expire_o (expire)
    );

    cm_own_fsm u_fsm (
        .clk (clk), .rst (rst), .req_i (req_i), .ack_s_i (ack_s),
        .done_i (done_i), .expire_i (expire), .ctl_o (ctl),
        .timeout_o (timeout_o)
    );

    assign drq_o         = ctl.drq;
    assign master_pull_o = ctl.master;
    assign drive_en_o    = ctl.drive;
    assign cmd_en_o      = ctl.cmd;
endmodule

// File: tb/casc_master_seq_bench.sv
module casc_master_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT = 112;

    logic clk = 1'b0, rst = 1'b1;
    logic req_i = 0, dack_i = 0, done_i = 0;
    logic drq_o, master_pull_o, drive_en_o, cmd_en_o, timeout_o;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    casc_master_seq #(.HOLD_LIMIT(LIMIT)) u_casc_master_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .dack_i(dack_i), .done_i(done_i),
        .drq_o(drq_o), .master_pull_o(master_pull_o), .drive_en_o(drive_en_o),
        .cmd_en_o(cmd_en_o), .timeout_o(timeout_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // cycles the master line stays pulled when done comes at command cycle d
    function automatic int exp_hold(input int d);
        int e = (d < LIMIT - 5) ? d : LIMIT - 5;
        return e + 5;
    endfunction

    function automatic int exp_cut(input int d);
        return (d >= LIMIT - 5) ? 1 : 0;
    endfunction

    task automatic own(input int dly, input int d);
        int k, mc, i;
        @(negedge clk) req_i = 1;
        @(negedge clk);
        chk("R2 drq after req", drq_o, 1);
        chk("R8 timeout cleared on new request", timeout_o, 0);
        for (int j = 0; j < dly; j++) begin
            @(negedge clk);
            chk("R3 no master before ack", master_pull_o, 0);
        end
        dack_i = 1;
        k = 0;
        do begin @(negedge clk); k++; end while (!master_pull_o && k < 10);
        chk("R3 master edges after ack", k, 3);
        chk("R4 no drive with master", drive_en_o, 0);
        req_i = 0;  // R9: dropping req during ownership has no effect
        mc = 1;
        @(negedge clk); mc++;
        chk("R4 drive one clock after master", drive_en_o, 1);
        chk("R5 no cmd yet", cmd_en_o, 0);
        @(negedge clk); mc++;
        chk("R5 cmd two clocks after master", cmd_en_o, 1);
        i = 0;
        while (cmd_en_o && i < 1000) begin
            done_i = (i == d);
            @(negedge clk);
            done_i = 0;
            if (cmd_en_o) begin mc++; i++; end
        end
        mc++;
        chk("R6 drive held after cmd drop", drive_en_o, 1);
        chk("R6 master held after cmd drop", master_pull_o, 1);
        @(negedge clk); mc++;
        chk("R6 drive dropped", drive_en_o, 0);
        chk("R6 master held after drive drop", master_pull_o, 1);
        @(negedge clk);
        chk("R6 master released", master_pull_o, 0);
        chk("R6 drq released with master", drq_o, 0);
        chk("R7 hold length", mc, exp_hold(d));
        chk("R8 timeout flag", timeout_o, exp_cut(d));
        dack_i = 0;
        repeat (4) @(negedge clk);
        chk("R9 stays idle", drq_o, 0);
        chk("R8 timeout kept in idle", timeout_o, exp_cut(d));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset drq", drq_o, 0);
        chk("R1 reset master", master_pull_o, 0);
        @(negedge clk) rst = 0;
        @(negedge clk);
        chk("R1 after reset outputs", {drq_o, master_pull_o, drive_en_o, cmd_en_o, timeout_o}, 0);
        dack_i = 1;
        repeat (5) begin
            @(negedge clk);
            chk("R2 dack ignored drq", drq_o, 0);
            chk("R2 dack ignored master", master_pull_o, 0);
        end
        dack_i = 0;
        repeat (4) @(negedge clk);
        own(0, 0);
        own(2, LIMIT - 6);
        own(1, LIMIT - 5);
        own(0, 3);
        own(3, 500);
        own(0, LIMIT - 4);
        for (int t = 0; t < 20; t++)
            own(int'($urandom_range(0, 5)), int'($urandom_range(0, LIMIT + 10)));
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule